// File: doc/BRIEF.md
# Watchdog Timer with Oscillator Stabilization Wait

One free-running counter, clocked by the system clock, does two jobs. After reset release, or when the stop input is released, the counter first times a programmable oscillator stabilization wait. It raises a stabilization-done flag when the wait ends. The counter then keeps running without a restart and serves as a watchdog. The wait length is picked from seven power-of-two taps, and the watchdog period from four longer power-of-two taps.

Software services the watchdog by writing the control register. If the selected period elapses with no service, the block emits a one-cycle interrupt pulse. If a second period then elapses with still no service, the block raises a system-reset request. This request stays high until the external reset is applied. A halt input freezes the counter. A stop input clears the counter and the stabilization flag, so the wait starts again when stop is released.

The parameters must place every stabilization tap below the shortest watchdog tap. With the defaults the stabilization taps are 2^2 to 2^14 cycles and the watchdog taps are 2^16 to 2^22 cycles.

Top module: `wdog_core`

## Requirements
- R1: An active-low reset clears the counter, the pending-overflow flag and all three outputs. It also clears the enable bit and the period select to 0 and sets the stabilization select to 6.
- R2: After reset or stop release, `stab_done_o` rises after 2^(STAB_BASE+STAB_STEP*s) counting cycles, where s is the stabilization select. Values 0 to 6 pick the taps in order, and value 7 acts as 6. The flag then stays high until the next reset or stop.
- R3: While `stop_i` is high, the counter, `stab_done_o` and the pending-overflow flag are held clear, and no interrupt is raised. Counting restarts from zero when stop is released.
- R4: While `halt_i` is high, the counter holds its value. No stabilization progress and no overflow happen during that time, so the pending deadlines move out by the number of halted cycles.
- R5: The watchdog period is 2^(WD_BASE+WD_STEP*p) counting cycles, measured from a zero counter. p is the control field at `wr_data_i[2:1]`.
- R6: An overflow raises `irq_o` for exactly one cycle. This happens only when the enable bit (`wr_data_i[0]` of the control write) is 1 and `stab_done_o` is high. With the enable bit at 0, no interrupt is raised.
- R7: An overflow that comes while an earlier overflow is still unserviced sets `rst_req_o` in the same cycle as its interrupt pulse. `rst_req_o` then stays high until reset.
- R8: A control write (`wr_en_i`=1, `wr_sel_i`=0) clears the counter and the pending-overflow flag. The next overflow therefore comes one full period after the write. A control write takes priority over an overflow in the same cycle.
- R9: A delay write (`wr_en_i`=1, `wr_sel_i`=1) loads `wr_data_i[2:0]` into the stabilization select. It does not clear the counter and does not clear `stab_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the counter counts its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 = control, 1 = stabilization delay |
| wr_data_i | input | 3 | Write data (control: bit0 enable, bits 2:1 period; delay: bits 2:0 select) |
| stop_i | input | 1 | Stop state: clears counter and stabilization flag |
| halt_i | input | 1 | Halt state: freezes the counter |
| irq_o | output | 1 | One-cycle watchdog interrupt pulse |
| stab_done_o | output | 1 | Stabilization wait finished |
| rst_req_o | output | 1 | Sticky system-reset request |

## Verification
A counter that is off by even one cycle shows up as an interrupt or stabilization edge one cycle early or late. The bench predicts these edges to the exact cycle and compares them on every clock, so such an error is caught at the first overflow or at the end of the first wait. A pending-overflow flag with the wrong value shows up at the next overflow: a reset request appears that should not, or is missing after the second unserviced period. A counter that fails to freeze during halt, or to clear on stop or on a service write, moves every later deadline, and the next edge the bench measures exposes it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int STAB_TAPS  = 7;
    localparam int WD_TAPS    = 4;
    localparam int STAB_SEL_W = 3;
    localparam int WD_SEL_W   = 2;
    localparam int CFG_W      = 3;

    localparam logic SEL_CTRL  = 1'b0;
    localparam logic SEL_DELAY = 1'b1;

    typedef struct packed {
        logic                  en;
        logic [WD_SEL_W-1:0]   per;
        logic [STAB_SEL_W-1:0] dly;
    } cfg_t;

    localparam cfg_t CFG_RST = '{en: 1'b0, per: '0, dly: 3'd6};
endpackage

// File: rtl/wdog_tap_match.sv
module wdog_tap_match #(
    parameter int W     = 8,
    parameter int BASE  = 1,
    parameter int STEP  = 1,
    parameter int TAPS  = 2,
    parameter int SEL_W = 1
) (
    input  logic [W-1:0]     cnt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    logic [TAPS-1:0]  hit_vec;
    logic [SEL_W-1:0] idx;

    // A tap is reached on the count just before its low bits wrap to zero.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        localparam int LEN = BASE + STEP * i;
        assign hit_vec[i] = &cnt_i[LEN-1:0];
    end

    // Select codes above the last tap saturate to the last tap.
    always_comb begin
        if (int'(sel_i) >= TAPS) idx = SEL_W'(TAPS - 1);
        else                     idx = sel_i;
    end

    assign hit_o = hit_vec[idx];
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int STAB_BASE = 2,
    parameter int STAB_STEP = 2,
    parameter int WD_BASE   = 16,
    parameter int WD_STEP   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic             stop_i,
    input  logic             halt_i,
    output logic             irq_o,
    output logic             stab_done_o,
    output logic             rst_req_o
);
    localparam int CNT_W  = WD_BASE + WD_STEP * (WD_TAPS - 1);
    localparam int STAB_W = STAB_BASE + STAB_STEP * (STAB_TAPS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             armed;
        logic             irq;
        logic             req;
        cfg_t             cfg;
    } state_t;

    localparam state_t ST_RST = '{cnt: '0, done: 1'b0, armed: 1'b0,
                                  irq: 1'b0, req: 1'b0, cfg: CFG_RST};

    state_t st_d, st_q;
    logic   ctl_wr, dly_wr, stab_hit, wd_hit;

    assign ctl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign dly_wr = wr_en_i && (wr_sel_i == SEL_DELAY);

    wdog_tap_match #(
        .W(STAB_W), .BASE(STAB_BASE), .STEP(STAB_STEP),
        .TAPS(STAB_TAPS), .SEL_W(STAB_SEL_W)
    ) u_stab_tap (
        .cnt_i (st_q.cnt[STAB_W-1:0]),
        .sel_i (st_q.cfg.dly),
        .hit_o (stab_hit)
    );

    wdog_tap_match #(
        .W(CNT_W), .BASE(WD_BASE), .STEP(WD_STEP),
        .TAPS(WD_TAPS), .SEL_W(WD_SEL_W)
    ) u_wd_tap (
        .cnt_i (st_q.cnt),
        .sel_i (st_q.cfg.per),
        .hit_o (wd_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        // Counter path: stop beats service write, service write beats counting.
        if (stop_i) begin
            st_d.cnt   = '0;
            st_d.done  = 1'b0;
            st_d.armed = 1'b0;
        end else if (ctl_wr) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (!halt_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (!st_q.done && stab_hit) begin
                st_d.done = 1'b1;
            end
            if (st_q.done && st_q.cfg.en && wd_hit) begin
                st_d.irq   = 1'b1;
                st_d.armed = 1'b1;
                if (st_q.armed) begin
                    st_d.req = 1'b1;
                end
            end
        end

        // Register writes.
        if (ctl_wr) begin
            st_d.cfg.en  = wr_data_i[0];
            st_d.cfg.per = wr_data_i[2:1];
        end
        if (dly_wr) begin
            st_d.cfg.dly = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_RST;
        else         st_q <= st_d;
    end

    assign irq_o       = st_q.irq;
    assign stab_done_o = st_q.done;
    assign rst_req_o   = st_q.req;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wr_en_i,
    input logic wr_sel_i,
    input logic stop_i,
    input logic halt_i,
    input logic irq_o,
    input logic stab_done_o,
    input logic rst_req_o
);
    a_r6_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> rst_req_o);

    a_r7_req_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> irq_o);

    a_r2_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stab_done_o && !stop_i) |=> stab_done_o);

    a_r3_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!stab_done_o && !irq_o));

    a_r4_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && !stop_i) |=> ($stable(stab_done_o) && !irq_o));

    a_r8_service_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_sel_i) |=> !irq_o);
endmodule

bind wdog_core wdog_core_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .stop_i      (stop_i),
    .halt_i      (halt_i),
    .irq_o       (irq_o),
    .stab_done_o (stab_done_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
    localparam int SB = 2;
    localparam int SS = 1;
    localparam int WB = 9;
    localparam int WS = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic       stop = 1'b0;
    logic       halt = 1'b0;
    logic       irq, sdone, req;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wdog_core #(
        .STAB_BASE(SB), .STAB_STEP(SS), .WD_BASE(WB), .WD_STEP(WS)
    ) u_wdog_core (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .stop_i(stop), .halt_i(halt),
        .irq_o(irq), .stab_done_o(sdone), .rst_req_o(req)
    );

    // Behavioural reference model
    int m_cnt, m_dly, m_per, slen, wlen;
    bit m_done, m_armed, m_irq, m_req, m_en, old_done, w_ctl, w_dly;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_armed = 0; m_irq = 0; m_req = 0;
            m_en = 0; m_per = 0; m_dly = 6;
        end else begin
            w_ctl    = wr_en && !wr_sel;
            w_dly    = wr_en && wr_sel;
            slen     = 1 << (SB + SS * ((m_dly > 6) ? 6 : m_dly));
            wlen     = 1 << (WB + WS * m_per);
            old_done = m_done;
            m_irq    = 0;
            if (stop) begin
                m_cnt = 0; m_done = 0; m_armed = 0;
            end else if (w_ctl) begin
                m_cnt = 0; m_armed = 0;
            end else if (!halt) begin
                if (!old_done && ((m_cnt + 1) % slen == 0)) m_done = 1;
                if (old_done && m_en && ((m_cnt + 1) % wlen == 0)) begin
                    m_irq = 1;
                    if (m_armed) m_req = 1;
                    m_armed = 1;
                end
                m_cnt = m_cnt + 1;
            end
            if (w_ctl) begin
                m_en  = wr_data[0];
                m_per = int'(wr_data[2:1]);
            end
            if (w_dly) m_dly = int'(wr_data);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (irq !== m_irq || sdone !== m_done || req !== m_req) errors++;
            if (irq !== m_irq)
                $display("FAIL R6 irq at cycle %0d: got %b expected %b", cyc, irq, m_irq);
            if (sdone !== m_done)
                $display("FAIL R2 stab_done at cycle %0d: got %b expected %b", cyc, sdone, m_done);
            if (req !== m_req)
                $display("FAIL R7 rst_req at cycle %0d: got %b expected %b", cyc, req, m_req);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Called at a falling edge: drive one write for one cycle.
    task automatic wr(input logic sel, input logic [2:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Cycles until stab_done (which=0) or irq (which=1) is seen high.
    task automatic measure(input int which, output int n);
        n = 0;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            n++;
            if ((which == 0) ? sdone : irq) return;
        end
        n = -1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        check("R1 irq in reset", int'(irq), 0);
        check("R1 stab_done in reset", int'(sdone), 0);
        check("R1 rst_req in reset", int'(req), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int n, cnt_irq;
        #1 rst_n = 1'b0;

        // R1/R2: default select 6 gives a 2^8 wait after reset
        do_reset();
        measure(0, n);
        check("R2 wait after reset with default select", n, 256);
        idle(300);
        check("R2 stab_done stays high", int'(sdone), 1);

        // R5/R6/R7: period 2^9, two unserviced overflows
        wr(1'b0, 3'b001);
        measure(1, n);
        check("R5 first overflow, period select 0", n, 512);
        check("R6 no reset request on first overflow", int'(req), 0);
        measure(1, n);
        check("R7 second overflow spacing", n, 512);
        check("R7 reset request on second overflow", int'(req), 1);
        idle(50);
        check("R7 reset request sticky", int'(req), 1);

        // R8: service write restarts the period and clears the pending flag
        do_reset();
        measure(0, n);
        wr(1'b0, 3'b101);
        idle(1000);
        wr(1'b0, 3'b101);
        measure(1, n);
        check("R8 overflow one period after service", n, 2048);
        check("R8 no reset request after service", int'(req), 0);

        // R5: longest period
        wr(1'b0, 3'b111);
        measure(1, n);
        check("R5 period select 3", n, 4096);

        // R4: halt freezes the counter
        wr(1'b0, 3'b001);
        idle(100);
        halt = 1'b1;
        idle(50);
        halt = 1'b0;
        measure(1, n);
        check("R4 overflow delayed by halted cycles", n, 412);

        // R9: delay write does not restart the counter
        wr(1'b0, 3'b001);
        idle(200);
        wr(1'b1, 3'b011);
        measure(1, n);
        check("R9 delay write keeps counter running", n, 311);
        check("R9 stab_done kept after delay write", int'(sdone), 1);

        // R6: enable clear suppresses interrupts
        wr(1'b0, 3'b000);
        cnt_irq = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (irq) cnt_irq++;
        end
        check("R6 no interrupt while disabled", cnt_irq, 0);

        // R3/R2: stop clears and restarts the wait with new selects
        stop = 1'b1;
        wr(1'b1, 3'b000);
        idle(2);
        check("R3 stab_done cleared by stop", int'(sdone), 0);
        stop = 1'b0;
        measure(0, n);
        check("R2 wait with select 0", n, 4);
        stop = 1'b1;
        wr(1'b1, 3'b011);
        stop = 1'b0;
        measure(0, n);
        check("R2 wait with select 3", n, 32);
        stop = 1'b1;
        wr(1'b1, 3'b111);
        stop = 1'b0;
        measure(0, n);
        check("R2 select 7 acts as 6", n, 256);

        // R3: stop clears the pending overflow
        wr(1'b0, 3'b001);
        measure(1, n);
        check("R3 first overflow before stop", n, 512);
        stop = 1'b1;
        idle(3);
        stop = 1'b0;
        measure(1, n);
        check("R3 overflow counted from stop release", n, 512);
        check("R3 no reset request after stop", int'(req), 0);

        idle(5);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule